// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps in-flight instructions in program order so that they can finish out of order but retire in order. A front end places each decoded instruction into a free slot at the tail. The slot index goes back to the front end as the instruction's tag. Functional units later report results against that tag, in any order. The oldest entry retires only when its result is present. Retiring either writes the destination register or releases a store to memory.

Later instructions can ask the buffer for uncommitted operands. Each source register is matched against every live entry that writes a register, and the youngest match answers. It returns the value if that entry has finished, and otherwise returns the producer's tag. When nothing matches, the operand must be read from the architectural register file.

Faults and branch mispredictions are acted on only when the offending entry reaches the head. A fault retires nothing: it empties the buffer and redirects fetch to a fixed handler address, reporting the faulting PC. A mispredicted branch retires itself, discards every younger entry, and redirects fetch to the corrected target that its functional unit supplied as its result.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `issue_ready_o` is 1, `issue_tag_o` is 0, `commit_valid_o`, `flush_o` and `exc_o` are 0, and no lookup port reports a hit.
- R2: An accepted issue takes the slot named by `issue_tag_o`. Successive accepted issues receive consecutive slot indices modulo DEPTH (8). `issue_ready_o` is 0 while DEPTH entries are held, and an issue offered then is not taken.
- R3: A completion stores `cmpl_result_i`, marks the tagged entry done, and records its fault and mispredict flags. A completion whose tag names no live entry has no effect.
- R4: Only the head entry may retire, and only once it is done. Entries retire in issue order, at most one per cycle. A retirement drives `commit_valid_o` with the entry's destination, PC and result. `commit_we_o` is 1 only for register-writing entries, and `commit_store_o` is 1 only for stores.
- R5: A done head entry with its fault flag set retires nothing. It raises `flush_o` and `exc_o`, drives `redirect_pc_o` to HANDLER_PC (0x100 by default), puts its PC on `exc_pc_o`, and empties the buffer.
- R6: A done head branch with its mispredict flag set retires (with `commit_branch_o` and its stored prediction on `commit_pred_o`), raises `flush_o` with `redirect_pc_o` equal to its result, and discards all younger entries. A correctly predicted branch retires without a flush.
- R7: For each lookup port, the youngest live register-writing entry whose destination equals the source reports `look_hit_o`=1. If that entry is done it reports `look_ready_o`=1 and its result on `look_value_o`; otherwise it reports `look_ready_o`=0 and its slot on `look_tag_o`.
- R8: A source that matches no live register-writing entry reports `look_hit_o`=0, meaning the operand comes from the register file.
- R9: In a flush cycle the issue offered is refused and the completion offered is ignored. Afterwards the buffer is empty. The next tag is the faulting slot after a fault, and the slot after the branch after a mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction offered for allocation |
| issue_dest_i | input | REG_W | Destination register |
| issue_wr_i | input | 1 | Instruction writes a register |
| issue_store_i | input | 1 | Instruction is a store |
| issue_branch_i | input | 1 | Instruction is a branch |
| issue_pred_i | input | 1 | Predicted direction of a branch |
| issue_pc_i | input | XLEN | Instruction PC |
| issue_ready_o | output | 1 | Allocation possible this cycle |
| issue_tag_o | output | IDX_W | Slot the offered instruction receives |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_tag_i | input | IDX_W | Slot of the completing instruction |
| cmpl_result_i | input | XLEN | Result, or corrected target for a branch |
| cmpl_exc_i | input | 1 | Instruction faulted |
| cmpl_mispred_i | input | 1 | Branch was mispredicted |
| look_reg_i | input | NLOOK x REG_W | Source registers to look up |
| look_hit_o | output | NLOOK | A buffered producer exists |
| look_ready_o | output | NLOOK | Producer's value is available |
| look_value_o | output | NLOOK x XLEN | Forwarded value |
| look_tag_o | output | NLOOK x IDX_W | Producer's slot |
| commit_valid_o | output | 1 | Head entry retires this cycle |
| commit_we_o | output | 1 | Retirement writes a register |
| commit_store_o | output | 1 | Retirement releases a store |
| commit_branch_o | output | 1 | Retiring entry is a branch |
| commit_pred_o | output | 1 | Stored prediction of the retiring branch |
| commit_dest_o | output | REG_W | Destination of the retiring entry |
| commit_data_o | output | XLEN | Result of the retiring entry |
| commit_pc_o | output | XLEN | PC of the retiring entry |
| flush_o | output | 1 | Buffer is being cleared |
| redirect_pc_o | output | XLEN | Fetch restart address during a flush |
| exc_o | output | 1 | Flush is caused by a fault |
| exc_pc_o | output | XLEN | PC of the faulting instruction |

## Verification
Directed sequences fill the buffer to capacity with eight writers of one register. Completing an older writer before the youngest shows whether the lookup picks the youngest match or merely the first done one. The same fill then retires into a fault that carries younger live entries and a simultaneous completion, which separates a head-only fault from a flush that leaks state. A mispredicted branch with finished younger entries behind it separates discarding those entries from retiring them. Seeded random issue and out-of-order completion, over a small register range with occasional faults and mispredicts, exercise pointer wrap, simultaneous issue and retire, and lookups against a model that tracks every slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HD_IDLE    = 2'd0,
    HD_COMMIT  = 2'd1,
    HD_BRFLUSH = 2'd2,
    HD_TRAP    = 2'd3
  } head_act_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic             flush_skip_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      // restart empty, at the fault slot or just past the branch
      head_q  <= flush_skip_i ? nxt(head_q) : head_q;
      tail_q  <= flush_skip_i ? nxt(head_q) : head_q;
      count_q <= '0;
    end else begin
      if (pop_i)  head_q <= nxt(head_q);
      if (push_i) tail_q <= nxt(tail_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_head_ctl.sv
module rob_head_ctl
  import rob_pkg::*;
(
  input  logic      valid_i,
  input  logic      done_i,
  input  logic      exc_i,
  input  logic      branch_i,
  input  logic      mispred_i,
  output head_act_e act_o
);
  always_comb begin
    act_o = HD_IDLE;
    if (valid_i && done_i) begin
      if (exc_i)                      act_o = HD_TRAP;
      else if (branch_i && mispred_i) act_o = HD_BRFLUSH;
      else                            act_o = HD_COMMIT;
    end
  end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int XLEN  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [REG_W-1:0]             src_i,
  input  logic [IDX_W-1:0]             head_i,
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0]             wr_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0][REG_W-1:0]  dest_i,
  input  logic [DEPTH-1:0][XLEN-1:0]   res_i,
  output logic                         hit_o,
  output logic                         ready_o,
  output logic [XLEN-1:0]              value_o,
  output logic [IDX_W-1:0]             tag_o
);
  // scan from oldest to youngest; the last match wins
  always_comb begin
    hit_o = 1'b0;
    tag_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = (int'(head_i) + k) % DEPTH;
      if (valid_i[idx] && wr_i[idx] && dest_i[idx] == src_i) begin
        hit_o = 1'b1;
        tag_o = IDX_W'(idx);
      end
    end
    ready_o = hit_o && done_i[tag_o];
    value_o = ready_o ? res_i[tag_o] : '0;
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int XLEN  = 32,
  parameter int NLOOK = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0100,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         issue_valid_i,
  input  logic [REG_W-1:0]             issue_dest_i,
  input  logic                         issue_wr_i,
  input  logic                         issue_store_i,
  input  logic                         issue_branch_i,
  input  logic                         issue_pred_i,
  input  logic [XLEN-1:0]              issue_pc_i,
  output logic                         issue_ready_o,
  output logic [IDX_W-1:0]             issue_tag_o,
  input  logic                         cmpl_valid_i,
  input  logic [IDX_W-1:0]             cmpl_tag_i,
  input  logic [XLEN-1:0]              cmpl_result_i,
  input  logic                         cmpl_exc_i,
  input  logic                         cmpl_mispred_i,
  input  logic [NLOOK-1:0][REG_W-1:0]  look_reg_i,
  output logic [NLOOK-1:0]             look_hit_o,
  output logic [NLOOK-1:0]             look_ready_o,
  output logic [NLOOK-1:0][XLEN-1:0]   look_value_o,
  output logic [NLOOK-1:0][IDX_W-1:0]  look_tag_o,
  output logic                         commit_valid_o,
  output logic                         commit_we_o,
  output logic                         commit_store_o,
  output logic                         commit_branch_o,
  output logic                         commit_pred_o,
  output logic [REG_W-1:0]             commit_dest_o,
  output logic [XLEN-1:0]              commit_data_o,
  output logic [XLEN-1:0]              commit_pc_o,
  output logic                         flush_o,
  output logic [XLEN-1:0]              redirect_pc_o,
  output logic                         exc_o,
  output logic [XLEN-1:0]              exc_pc_o
);
  logic [DEPTH-1:0]            e_valid, e_done, e_exc, e_mis;
  logic [DEPTH-1:0]            e_wr, e_st, e_br, e_pred;
  logic [DEPTH-1:0][REG_W-1:0] e_dest;
  logic [DEPTH-1:0][XLEN-1:0]  e_pc, e_res;

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, push, pop;
  head_act_e        act;

  rob_head_ctl u_head_ctl (
    .valid_i   (e_valid[head]),
    .done_i    (e_done[head]),
    .exc_i     (e_exc[head]),
    .branch_i  (e_br[head]),
    .mispred_i (e_mis[head]),
    .act_o     (act)
  );

  assign flush_o       = (act == HD_BRFLUSH) || (act == HD_TRAP);
  assign exc_o         = (act == HD_TRAP);
  assign issue_ready_o = !full && !flush_o;
  assign issue_tag_o   = tail;
  assign push          = issue_valid_i && issue_ready_o;
  assign pop           = (act == HD_COMMIT) || (act == HD_BRFLUSH);

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .pop_i        (pop),
    .flush_i      (flush_o),
    .flush_skip_i (act == HD_BRFLUSH),
    .head_o       (head),
    .tail_o       (tail),
    .count_o      (count),
    .full_o       (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_valid <= '0;
      e_done  <= '0;
      e_exc   <= '0;
      e_mis   <= '0;
      e_wr    <= '0;
      e_st    <= '0;
      e_br    <= '0;
      e_pred  <= '0;
      e_dest  <= '0;
      e_pc    <= '0;
      e_res   <= '0;
    end else if (flush_o) begin
      e_valid <= '0;
    end else begin
      if (pop) e_valid[head] <= 1'b0;
      // late reports for dead slots are dropped
      if (cmpl_valid_i && e_valid[cmpl_tag_i]) begin
        e_done[cmpl_tag_i] <= 1'b1;
        e_res[cmpl_tag_i]  <= cmpl_result_i;
        e_exc[cmpl_tag_i]  <= cmpl_exc_i;
        e_mis[cmpl_tag_i]  <= cmpl_mispred_i;
      end
      if (push) begin
        e_valid[tail] <= 1'b1;
        e_done[tail]  <= 1'b0;
        e_exc[tail]   <= 1'b0;
        e_mis[tail]   <= 1'b0;
        e_wr[tail]    <= issue_wr_i;
        e_st[tail]    <= issue_store_i;
        e_br[tail]    <= issue_branch_i;
        e_pred[tail]  <= issue_pred_i;
        e_dest[tail]  <= issue_dest_i;
        e_pc[tail]    <= issue_pc_i;
      end
    end
  end

  assign commit_valid_o  = pop;
  assign commit_we_o     = pop && e_wr[head];
  assign commit_store_o  = pop && e_st[head];
  assign commit_branch_o = pop && e_br[head];
  assign commit_pred_o   = pop && e_pred[head];
  assign commit_dest_o   = e_dest[head];
  assign commit_data_o   = e_res[head];
  assign commit_pc_o     = e_pc[head];
  assign redirect_pc_o   = (act == HD_TRAP)    ? HANDLER_PC :
                           (act == HD_BRFLUSH) ? e_res[head] : '0;
  assign exc_pc_o        = exc_o ? e_pc[head] : '0;

  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .XLEN(XLEN)) u_lookup (
      .src_i   (look_reg_i[g]),
      .head_i  (head),
      .valid_i (e_valid),
      .wr_i    (e_wr),
      .done_i  (e_done),
      .dest_i  (e_dest),
      .res_i   (e_res),
      .hit_o   (look_hit_o[g]),
      .ready_o (look_ready_o[g]),
      .value_o (look_value_o[g]),
      .tag_o   (look_tag_o[g])
    );
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int NLOOK = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0100,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic [IDX_W-1:0] issue_tag_o,
  input logic             commit_valid_o,
  input logic             flush_o,
  input logic             exc_o,
  input logic [XLEN-1:0]  redirect_pc_o,
  input logic [NLOOK-1:0] look_hit_o,
  input logic [NLOOK-1:0] look_ready_o,
  input logic [CNT_W-1:0] count
);
  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  a_r2_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH)) |-> !issue_ready_o);
  a_r2_tag_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o) |=> issue_tag_o == nxt($past(issue_tag_o)));
  a_r5_trap_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (flush_o && !commit_valid_o));
  a_r5_trap_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> redirect_pc_o == HANDLER_PC);
  a_r9_empty_after_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (count == '0 && !flush_o && !commit_valid_o));
  a_r7_ready_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (look_ready_o & ~look_hit_o) == '0);
endmodule

bind rob_core rob_core_chk #(
  .DEPTH(DEPTH), .XLEN(XLEN), .NLOOK(NLOOK), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .issue_valid_i  (issue_valid_i),
  .issue_ready_o  (issue_ready_o),
  .issue_tag_o    (issue_tag_o),
  .commit_valid_o (commit_valid_o),
  .flush_o        (flush_o),
  .exc_o          (exc_o),
  .redirect_pc_o  (redirect_pc_o),
  .look_hit_o     (look_hit_o),
  .look_ready_o   (look_ready_o),
  .count          (count)
);

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int D = 8;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic issue_valid, issue_wr, issue_store, issue_branch, issue_pred;
  logic [4:0] issue_dest;
  logic [31:0] issue_pc;
  logic issue_ready;
  logic [2:0] issue_tag;
  logic cmpl_valid, cmpl_exc, cmpl_mis;
  logic [2:0] cmpl_tag;
  logic [31:0] cmpl_res;
  logic [1:0][4:0] look_reg;
  logic [1:0] look_hit, look_rdy;
  logic [1:0][31:0] look_val;
  logic [1:0][2:0] look_tag;
  logic c_valid, c_we, c_st, c_br, c_pred, flush, exc;
  logic [4:0] c_dest;
  logic [31:0] c_data, c_pc, redir, exc_pc;

  rob_core u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_dest_i(issue_dest), .issue_wr_i(issue_wr),
    .issue_store_i(issue_store), .issue_branch_i(issue_branch), .issue_pred_i(issue_pred),
    .issue_pc_i(issue_pc), .issue_ready_o(issue_ready), .issue_tag_o(issue_tag),
    .cmpl_valid_i(cmpl_valid), .cmpl_tag_i(cmpl_tag), .cmpl_result_i(cmpl_res),
    .cmpl_exc_i(cmpl_exc), .cmpl_mispred_i(cmpl_mis),
    .look_reg_i(look_reg), .look_hit_o(look_hit), .look_ready_o(look_rdy),
    .look_value_o(look_val), .look_tag_o(look_tag),
    .commit_valid_o(c_valid), .commit_we_o(c_we), .commit_store_o(c_st),
    .commit_branch_o(c_br), .commit_pred_o(c_pred), .commit_dest_o(c_dest),
    .commit_data_o(c_data), .commit_pc_o(c_pc), .flush_o(flush),
    .redirect_pc_o(redir), .exc_o(exc), .exc_pc_o(exc_pc)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // model of every slot
  bit m_v[D], m_done[D], m_exc[D], m_mis[D], m_wr[D], m_st[D], m_br[D], m_pred[D];
  logic [4:0] m_dest[D];
  logic [31:0] m_pc[D], m_res[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  logic [31:0] pc_ctr = 32'h1000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 idle, 1 retire, 2 retire and flush, 3 fault
  function automatic int head_act();
    if (!(m_v[m_head] && m_done[m_head])) return 0;
    if (m_exc[m_head]) return 3;
    if (m_br[m_head] && m_mis[m_head]) return 2;
    return 1;
  endfunction

  task automatic check_look(input int p, input logic [4:0] r);
    int y = -1;
    for (int k = 0; k < D; k++) begin
      int idx = (m_head + k) % D;
      if (m_v[idx] && m_wr[idx] && m_dest[idx] == r) y = idx;
    end
    if (y < 0) chk("R8 no-match hit", 32'(look_hit[p]), 0);
    else begin
      chk("R7 hit", 32'(look_hit[p]), 1);
      chk("R7 ready", 32'(look_rdy[p]), 32'(m_done[y]));
      if (m_done[y]) chk("R7 value", look_val[p], m_res[y]);
      else chk("R7 producer tag", 32'(look_tag[p]), 32'(y));
    end
  endtask

  // called just after a falling edge; returns after the next falling edge
  task automatic step(input bit iv, input logic [4:0] idst, input bit iwr, ist, ibr, ipred,
                      input bit cv, input int ctag, input logic [31:0] cres, input bit cexc, cmis,
                      input logic [4:0] l0, l1);
    int a;
    bit acc;
    issue_valid = iv; issue_dest = idst; issue_wr = iwr; issue_store = ist;
    issue_branch = ibr; issue_pred = ipred; issue_pc = pc_ctr;
    cmpl_valid = cv; cmpl_tag = 3'(ctag); cmpl_res = cres; cmpl_exc = cexc; cmpl_mis = cmis;
    look_reg[0] = l0; look_reg[1] = l1;
    #1;
    a = head_act();
    chk(a >= 2 ? "R9 ready in flush" : "R2 ready", 32'(issue_ready), 32'(m_cnt < D && a < 2));
    chk("R2 tag", 32'(issue_tag), 32'(m_tail));
    chk("R4 commit valid", 32'(c_valid), 32'(a == 1 || a == 2));
    if (a == 1 || a == 2) begin
      chk("R4 we", 32'(c_we), 32'(m_wr[m_head]));
      chk("R4 store", 32'(c_st), 32'(m_st[m_head]));
      chk("R4 pc", c_pc, m_pc[m_head]);
      chk("R6 branch", 32'(c_br), 32'(m_br[m_head]));
      if (m_br[m_head]) chk("R6 pred", 32'(c_pred), 32'(m_pred[m_head]));
      if (m_wr[m_head]) chk("R4 dest", 32'(c_dest), 32'(m_dest[m_head]));
      if (!m_br[m_head]) chk("R3 data", c_data, m_res[m_head]);
    end
    chk(a == 3 ? "R5 flush" : "R6 flush", 32'(flush), 32'(a >= 2));
    chk("R5 exc", 32'(exc), 32'(a == 3));
    if (a == 3) begin
      chk("R5 redirect", redir, HPC);
      chk("R5 fault pc", exc_pc, m_pc[m_head]);
    end
    if (a == 2) chk("R6 redirect", redir, m_res[m_head]);
    check_look(0, l0);
    check_look(1, l1);
    // model update for the coming edge
    if (a >= 2) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
      if (a == 2) m_head = (m_head + 1) % D;
      m_tail = m_head; m_cnt = 0;
    end else begin
      acc = iv && (m_cnt < D);
      if (a == 1) begin m_v[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--; end
      if (cv && m_v[ctag]) begin
        m_done[ctag] = 1; m_res[ctag] = cres; m_exc[ctag] = cexc; m_mis[ctag] = cmis;
      end
      if (acc) begin
        m_v[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0; m_mis[m_tail] = 0;
        m_wr[m_tail] = iwr; m_st[m_tail] = ist; m_br[m_tail] = ibr; m_pred[m_tail] = ipred;
        m_dest[m_tail] = idst; m_pc[m_tail] = pc_ctr;
        m_tail = (m_tail + 1) % D; m_cnt++;
        pc_ctr += 4;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [4:0] l0, l1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, l0, l1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    void'($urandom(32'd2718));
    issue_valid = 0; issue_dest = 0; issue_wr = 0; issue_store = 0; issue_branch = 0;
    issue_pred = 0; issue_pc = 0; cmpl_valid = 0; cmpl_tag = 0; cmpl_res = 0;
    cmpl_exc = 0; cmpl_mis = 0; look_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ready", 32'(issue_ready), 1);
    chk("R1 tag", 32'(issue_tag), 0);
    chk("R1 commit", 32'(c_valid), 0);
    chk("R1 flush", 32'({flush, exc}), 0);
    chk("R1 no hit", 32'(look_hit), 0);
    @(negedge clk);

    // fill with eight writers of r5, offer a ninth (refused: R2)
    for (int i = 0; i < 9; i++) step(1, 5'd5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd5, 5'd6);
    // older writer done, youngest still pending (R7)
    step(0, 0, 0, 0, 0, 0, 1, 3, 32'h33, 0, 0, 5'd5, 5'd0);
    step(0, 0, 0, 0, 0, 0, 1, 7, 32'h77, 0, 0, 5'd5, 5'd5);
    idle(5'd5, 5'd6);
    // head retires, then slot 1 faults with younger entries live (R5)
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'h10, 0, 0, 5'd5, 5'd1);
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h11, 1, 0, 5'd5, 5'd1);
    // fault cycle: issue and completion offered (R9)
    step(1, 5'd9, 1, 0, 0, 0, 1, 2, 32'h22, 0, 0, 5'd5, 5'd9);
    idle(5'd5, 5'd9);

    // branch, two finished writers behind it, then mispredict (R6)
    step(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 5'd3, 5'd4);
    step(1, 5'd3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 5'd3, 5'd4);
    step(1, 5'd4, 0, 1, 0, 0, 1, 2, 32'hA2, 0, 0, 5'd3, 5'd4);
    step(0, 0, 0, 0, 0, 0, 1, 3, 32'hA3, 0, 0, 5'd3, 5'd4);
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h2000, 0, 1, 5'd3, 5'd4);
    idle(5'd3, 5'd4);
    idle(5'd3, 5'd4);
    // correctly predicted branch retires without flush (R6)
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 5'd0, 5'd0);
    step(0, 0, 0, 0, 0, 0, 1, m_head, 32'h0, 0, 0, 5'd0, 5'd0);
    idle(5'd0, 5'd0);

    // seeded random mix
    for (int c = 0; c < 4000; c++) begin
      bit iv, ist, ibr, cv, cexc, cmis;
      int ctag = 0;
      logic [4:0] dst;
      iv = ($urandom % 3) != 0;
      ibr = ($urandom % 6) == 0;
      ist = !ibr && ($urandom % 6) == 0;
      dst = 5'($urandom % 8);
      cv = 0;
      if ($urandom % 3 != 0) begin
        int st0 = $urandom % D;
        for (int k = 0; k < D; k++) begin
          int t = (st0 + k) % D;
          if (!cv && m_v[t] && !m_done[t]) begin cv = 1; ctag = t; end
        end
      end
      cexc = ($urandom % 24) == 0;
      cmis = cv && m_br[ctag] && ($urandom % 4) == 0;
      step(iv, dst, !ibr && !ist, ist, ibr, 1'($urandom), cv, ctag, $urandom, cexc, cmis,
           5'($urandom % 8), 5'($urandom % 8));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule